// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupt sources and a processor core that has two interrupt inputs: a normal request line and a fast request line, both active low. Each normal source is given a priority from 1 to 7 through a static configuration input. Priority 0 turns a source off. A separate fast source has its own capture flag and its own output, and the level logic never touches it.

Software works the block through a small register bus with four addresses. Reading the number register both identifies the winning source and acknowledges it. The acknowledge marks the winning priority as in service in a per-level bitmap and releases the request line. The request line is asserted again only when a pending request has a priority strictly above every level that is still in service, so nested servicing is enforced in hardware. A write to the bitmap address at the end of a service routine retires the most recent (highest) in-service level.

A two-state sequencer drives the request line. The state **S_QUIET** means the line is high and the level register holds 0. The state **S_RAISED** means the line is low and the level register holds the winning priority. The transitions are:
- **raise**: S_QUIET to S_RAISED when an eligible request exists.
- **track**: S_RAISED to S_RAISED, where the level and number follow the current winner.
- **ack**: S_RAISED to S_QUIET on a number read.
- **withdraw**: S_RAISED to S_QUIET when no eligible request is left.
- **idle**: S_QUIET to S_QUIET.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, both n_irq and n_fiq are high, and all four registers read 0.
- R2: When a request with level N is pending and N is above every in-service level, n_irq goes low one cycle later and address 0 reads N. While n_irq is high, address 0 reads 0.
- R3: Among pending sources the highest level wins, and ties go to the lowest source index. A read of address 1 returns the winner's index.
- R4: A read of address 1 while n_irq is low sets bit N of the in-service bitmap (address 2, bit i stands for level i). N is the level held at address 0. n_irq is high from the next cycle.
- R5: A pending request whose level is equal to or below the highest in-service bit keeps n_irq high. A strictly higher request lowers n_irq again, and successive acknowledges accumulate bits, for example levels 2 and 7 give 0x84.
- R6: Any write to address 2 clears only the highest set bit of the bitmap. Lower-level requests then become eligible again.
- R7: A source configured with level 0 never causes a request.
- R8: A rising edge on fiq_src sets the fast flag (address 3, bit 0) and drives n_fiq low one cycle later. This happens whatever the state of the normal request logic.
- R9: A write to address 3 with bit 0 equal to 0 clears the fast flag, and n_fiq is high the next cycle. Holding fiq_src high after that does not set the flag again. Writing 1 has no effect.
- R10: If a fiq_src rising edge and a clearing write to address 3 fall in the same cycle, the flag is set.
- R11: A read of address 1 while n_irq is high leaves the bitmap unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_src | input | NUM_SRC | Request from each normal source, active high |
| irq_lvl_cfg | input | NUM_SRC*LVL_W | Priority of each source; source i occupies bits i*LVL_W and up |
| fiq_src | input | 1 | Fast interrupt source, captured on its rising edge |
| bus_addr | input | 2 | Register address: 0 level, 1 number, 2 in-service bitmap, 3 fast flag |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the addressed register |
| n_irq | output | 1 | Normal interrupt request to the core, active low |
| n_fiq | output | 1 | Fast interrupt request to the core, active low |

## Verification
Two functions can land in the same clock edge: capture of a new fast-source edge and the software write that clears the fast flag. The bench provokes this by raising fiq_src in the very cycle the clearing write is strobed. It judges the outcome by n_fiq staying low and by the flag reading 1 afterwards. Acknowledge and end-of-service share one bus, so they cannot coincide. Randomized request patterns and priority maps are run against a bench-side model of the bitmap to exercise nesting depth.

// File: rtl/nic_pkg.sv
package nic_pkg;
    typedef enum logic {
        S_QUIET  = 1'b0,
        S_RAISED = 1'b1
    } irq_state_t;

    localparam logic [1:0] A_REQLVL = 2'd0;
    localparam logic [1:0] A_INTNUM = 2'd1;
    localparam logic [1:0] A_INSVC  = 2'd2;
    localparam logic [1:0] A_FIQ    = 2'd3;
endpackage

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 3,
    parameter int SRC_W   = 3
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_cfg,
    output logic [LVL_W-1:0]         win_lvl,
    output logic [SRC_W-1:0]         win_idx
);
    logic [LVL_W-1:0] eff_lvl [NUM_SRC];

    // masked level per source: zero when not requesting
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
        assign eff_lvl[g] = req[g] ? lvl_cfg[g*LVL_W +: LVL_W] : '0;
    end

    // scan downward so an equal level at a lower index replaces the current pick
    always_comb begin
        win_lvl = '0;
        win_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (eff_lvl[i] != '0 && eff_lvl[i] >= win_lvl) begin
                win_lvl = eff_lvl[i];
                win_idx = SRC_W'(i);
            end
        end
    end
endmodule

// File: rtl/nic_level_track.sv
module nic_level_track #(
    parameter int LVL_W   = 3,
    parameter int NUM_LVL = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [LVL_W-1:0]   set_lvl,
    input  logic               clr_top,
    output logic [NUM_LVL-1:0] busy_map,
    output logic [LVL_W-1:0]   busy_top
);
    logic [NUM_LVL-1:0] set_oh;
    logic [NUM_LVL-1:0] top_oh;

    always_comb begin
        busy_top = '0;
        for (int i = 1; i < NUM_LVL; i++) begin
            if (busy_map[i]) busy_top = LVL_W'(i);
        end
    end

    assign set_oh = (set_lvl != '0) ? (NUM_LVL'(1) << set_lvl) : '0;
    assign top_oh = (busy_top != '0) ? (NUM_LVL'(1) << busy_top) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_map <= '0;
        end else if (set_en) begin
            busy_map <= busy_map | set_oh;
        end else if (clr_top) begin
            busy_map <= busy_map & ~top_oh;
        end
    end
endmodule

// File: rtl/nic_fiq.sv
module nic_fiq (
    input  logic clk,
    input  logic rst,
    input  logic fiq_in,
    input  logic clr,
    output logic flag
);
    logic fiq_d;
    logic rise;

    assign rise = fiq_in && !fiq_d;

    // a fresh edge outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            fiq_d <= 1'b0;
            flag  <= 1'b0;
        end else begin
            fiq_d <= fiq_in;
            if (rise)     flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 3,
    parameter int DATA_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC-1:0]       irq_src,
    input  logic [NUM_SRC*LVL_W-1:0] irq_lvl_cfg,
    input  logic                     fiq_src,
    input  logic [1:0]               bus_addr,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     n_irq,
    output logic                     n_fiq
);
    localparam int NUM_LVL = 1 << LVL_W;
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [LVL_W-1:0]   win_lvl;
    logic [SRC_W-1:0]   win_idx;
    logic [NUM_LVL-1:0] busy_map;
    logic [LVL_W-1:0]   busy_top;
    logic [LVL_W-1:0]   req_lvl_q;
    logic [SRC_W-1:0]   src_num_q;
    logic               fiq_flag;
    irq_state_t         state_q, state_d;

    logic eligible, ack, end_svc, fiq_clr;

    assign eligible = (win_lvl > busy_top);
    assign ack      = bus_rd && (bus_addr == A_INTNUM) && (state_q == S_RAISED);
    assign end_svc  = bus_wr && (bus_addr == A_INSVC);
    assign fiq_clr  = bus_wr && (bus_addr == A_FIQ) && !bus_wdata[0];

    nic_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .SRC_W(SRC_W)) u_arb (
        .req     (irq_src),
        .lvl_cfg (irq_lvl_cfg),
        .win_lvl (win_lvl),
        .win_idx (win_idx)
    );

    nic_level_track #(.LVL_W(LVL_W), .NUM_LVL(NUM_LVL)) u_track (
        .clk      (clk),
        .rst      (rst),
        .set_en   (ack),
        .set_lvl  (req_lvl_q),
        .clr_top  (end_svc),
        .busy_map (busy_map),
        .busy_top (busy_top)
    );

    nic_fiq u_fiq (
        .clk    (clk),
        .rst    (rst),
        .fiq_in (fiq_src),
        .clr    (fiq_clr),
        .flag   (fiq_flag)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_QUIET:  state_d = eligible ? S_RAISED : S_QUIET;
            S_RAISED: begin
                if (ack)           state_d = S_QUIET;
                else if (!eligible) state_d = S_QUIET;
                else               state_d = S_RAISED;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_QUIET;
        else     state_q <= state_d;
    end

    // registered outputs of the sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            req_lvl_q <= '0;
            src_num_q <= '0;
        end else begin
            unique case (state_q)
                S_QUIET: begin
                    if (eligible) begin
                        req_lvl_q <= win_lvl;
                        src_num_q <= win_idx;
                    end
                end
                S_RAISED: begin
                    if (ack || !eligible) begin
                        req_lvl_q <= '0;
                    end else begin
                        req_lvl_q <= win_lvl;
                        src_num_q <= win_idx;
                    end
                end
            endcase
        end
    end

    assign n_irq = (state_q != S_RAISED);
    assign n_fiq = !fiq_flag;

    always_comb begin
        unique case (bus_addr)
            A_REQLVL: bus_rdata = DATA_W'(req_lvl_q);
            A_INTNUM: bus_rdata = DATA_W'(src_num_q);
            A_INSVC:  bus_rdata = DATA_W'(busy_map);
            A_FIQ:    bus_rdata = DATA_W'(fiq_flag);
        endcase
    end
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
    parameter int LVL_W   = 3,
    parameter int NUM_LVL = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               n_irq,
    input logic               n_fiq,
    input logic               fiq_src,
    input logic [1:0]         bus_addr,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic               wdata_b0,
    input logic [NUM_LVL-1:0] busy_map,
    input logic [LVL_W-1:0]   busy_top,
    input logic [LVL_W-1:0]   req_lvl_q
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (n_irq && n_fiq));

    // R5
    raise_above_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !n_irq |-> (req_lvl_q > busy_top));

    // R4
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd1 && !n_irq) |=> (n_irq && busy_map[$past(req_lvl_q)]));

    // R6
    end_svc_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd2 && busy_map != '0)
        |=> (int'($countones(busy_map)) + 1 == int'($countones($past(busy_map)))));

    // R11
    idle_read_no_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd1 && n_irq && !bus_wr) |=> $stable(busy_map));

    // R8
    fiq_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fiq_src) |=> !n_fiq);

    // R9
    fiq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3 && !wdata_b0 && !$rose(fiq_src)) |=> n_fiq);
endmodule

bind nest_irq_ctrl nic_chk #(.LVL_W(LVL_W), .NUM_LVL(NUM_LVL)) u_nic_chk (
    .clk       (clk),
    .rst       (rst),
    .n_irq     (n_irq),
    .n_fiq     (n_fiq),
    .fiq_src   (fiq_src),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .wdata_b0  (bus_wdata[0]),
    .busy_map  (busy_map),
    .busy_top  (busy_top),
    .req_lvl_q (req_lvl_q)
);

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] irq_src = '0;
    logic [NS*3-1:0] irq_lvl_cfg;
    logic          fiq_src = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          n_irq, n_fiq;

    logic [2:0] lvl [NS];
    int errors = 0;
    int checks = 0;
    logic [7:0] m_map;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) irq_lvl_cfg[i*3 +: 3] = lvl[i];
    end

    nest_irq_ctrl #(.NUM_SRC(NS), .LVL_W(3), .DATA_W(8)) uut (
        .clk(clk), .rst(rst), .irq_src(irq_src), .irq_lvl_cfg(irq_lvl_cfg),
        .fiq_src(fiq_src), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .n_irq(n_irq), .n_fiq(n_fiq)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    function automatic void model_win(input logic [NS-1:0] r, output int wl, output int wi);
        wl = 0; wi = 0;
        for (int i = 0; i < NS; i++) begin
            if (r[i] && int'(lvl[i]) > wl) begin wl = int'(lvl[i]); wi = i; end
        end
    endfunction

    function automatic int model_top(input logic [7:0] m);
        int t = 0;
        for (int i = 1; i < 8; i++) if (m[i]) t = i;
        return t;
    endfunction

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v, wl, wi, op;
        for (int i = 0; i < NS; i++) lvl[i] = '0;
        v = int'($urandom(32'd20240611));
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        chk("R1 n_irq", n_irq, 1);
        chk("R1 n_fiq", n_fiq, 1);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg", v, 0);
        end

        // R7 level 0 source ignored
        irq_src = 8'h01; cyc(2);
        chk("R7 n_irq", n_irq, 1);
        rd(2'd0, v); chk("R7 level", v, 0);
        irq_src = '0;

        // R2/R4/R5 nesting 2 then 7
        lvl[1] = 3'd2; lvl[3] = 3'd2; lvl[5] = 3'd7;
        irq_src = 8'h02; cyc(1);
        chk("R2 n_irq low", n_irq, 0);
        rd(2'd0, v); chk("R2 level", v, 2);
        rd(2'd1, v); chk("R3 number", v, 1);
        chk("R4 release", n_irq, 1);
        rd(2'd2, v); chk("R4 map", v, 8'h04);
        irq_src = 8'h0A; cyc(2);
        chk("R5 equal level held", n_irq, 1);
        irq_src = 8'h2A; cyc(1);
        chk("R5 higher raises", n_irq, 0);
        rd(2'd0, v); chk("R5 level", v, 7);

        // R8 fast source while nested
        fiq_src = 1'b1; cyc(1);
        chk("R8 n_fiq", n_fiq, 0);
        rd(2'd1, v); chk("R3 number", v, 5);
        rd(2'd2, v); chk("R5 map", v, 8'h84);
        rd(2'd3, v); chk("R8 flag", v, 1);
        chk("R8 irq unaffected", n_irq, 1);

        // R9 clear, held input, write 1 no effect
        wr(2'd3, 8'h00);
        chk("R9 n_fiq", n_fiq, 1);
        cyc(3);
        chk("R9 held no reset", n_fiq, 1);
        wr(2'd3, 8'h01);
        rd(2'd3, v); chk("R9 write1", v, 0);
        fiq_src = 1'b0; cyc(1);

        // R6 end of service
        irq_src = 8'h0A;
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R6 top cleared", v, 8'h04);
        chk("R6 level2 still blocked", n_irq, 1);
        wr(2'd2, 8'h00); cyc(1);
        chk("R6 reenabled", n_irq, 0);
        rd(2'd0, v); chk("R6 level", v, 2);
        rd(2'd1, v); chk("R3 tie lowest", v, 1);
        wr(2'd2, 8'h00);
        irq_src = '0; cyc(2);

        // R11 idle number read
        rd(2'd1, v);
        rd(2'd2, v); chk("R11 map", v, 0);
        rd(2'd0, v); chk("R2 idle level", v, 0);

        // R3 mixed levels
        lvl[2] = 3'd4; lvl[6] = 3'd6; lvl[4] = 3'd6;
        irq_src = 8'h54; cyc(1);
        rd(2'd0, v); chk("R3 level", v, 6);
        rd(2'd1, v); chk("R3 number", v, 4);
        wr(2'd2, 8'h00); irq_src = '0; cyc(2);

        // R10 edge and clear together
        bus_addr = 2'd3; bus_wdata = 8'h00; bus_wr = 1'b1; fiq_src = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 n_fiq", n_fiq, 0);
        rd(2'd3, v); chk("R10 flag", v, 1);
        wr(2'd3, 8'h00); fiq_src = 1'b0; cyc(1);

        // random phase with bench model of the bitmap
        m_map = '0;
        for (int it = 0; it < 400; it++) begin
            for (int i = 0; i < NS; i++) lvl[i] = 3'($urandom);
            irq_src = NS'($urandom);
            cyc(1);
            model_win(irq_src, wl, wi);
            chk("R5 random raise", n_irq, (wl > model_top(m_map)) ? 0 : 1);
            op = int'($urandom % 3);
            if (wl > model_top(m_map)) begin
                rd(2'd0, v); chk("R2 random level", v, wl);
                if (op == 0) begin
                    rd(2'd1, v); chk("R3 random number", v, wi);
                    m_map[wl] = 1'b1;
                end
            end
            if (op == 1) begin
                wr(2'd2, 8'h00);
                if (model_top(m_map) != 0) m_map[model_top(m_map)] = 1'b0;
            end
            rd(2'd2, v); chk("R4 random map", v, int'(m_map));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule